// File: doc/BRIEF.md
# Serial-Bus Supply Control Register

This block is the host-facing control point of an antenna-feed supply controller. A host on a two-wire I2C bus writes one 8-bit control byte. The byte's fields go out as level signals to the rest of the controller:

- enable
- voltage select
- line-loss compensation
- tone enable
- transmit enable
- auxiliary high-voltage
- current-test level
- pulsed current limiting

When the host reads, it gets a different 8-bit status byte. That byte joins five live diagnostic flags with an echo of the three voltage-related control bits. The diagnostic flags come from analog monitors elsewhere and arrive here as synchronous inputs.

The block also decodes a 3-bit output-voltage target code. The decode uses the control bits and an external voltage-control pin, in a fixed priority order. Bus lines are oversampled on the system clock through a two-flop synchronizer. A state machine follows the byte protocol:

- IDLE waits for a START.
- ADDR shifts in the address byte.
- ADDR_ACK acknowledges a matching address.
- WR_DATA and WR_ACK receive and acknowledge written bytes.
- RD_DATA shifts out the status byte.
- RD_ACK samples the host's acknowledge.

The transitions are:

- START from any state goes to ADDR, which gives repeated START.
- STOP from any state goes to IDLE.
- A non-matching address goes from ADDR to IDLE.
- ADDR_ACK goes to RD_DATA or WR_DATA according to the direction bit.
- WR_ACK returns to WR_DATA.
- RD_ACK goes to RD_DATA after a host ACK, or to IDLE after a NACK.

Top module: `supi2c_ctl_regs`

## Requirements
- R1: After reset every control output is 0, the voltage target code is 0 (off) and the data line is released (sda_oe=0).
- R2: The target acknowledges address ADDR_LO (default 0x08) when addr_sel=0 and ADDR_HI (default 0x09) when addr_sel=1. Every other 7-bit address gets a NACK, and any byte that follows it leaves the control outputs unchanged.
- R3: A written data byte maps bit 0 to enable, bit 1 to voltage select, bit 2 to line-loss compensation, bit 3 to tone enable, bit 4 to transmit enable, bit 5 to pulsed current limiting, bit 6 to current-test level and bit 7 to auxiliary. The byte takes effect on its ACK, and each further byte in the same transfer overwrites the register.
- R4: The read byte is {llc, vsel, en, diag[4], diag[3], diag[2], diag[1], diag[0]}, MSB first. The diag bits are minimum-current, output-voltage, tone, over-temperature and overload, in that order from bit 4 down. With all flags at 0, only the echo bits can be non-zero.
- R5: The output-voltage flag (read bit 3) reads 0 whenever the line-loss compensation bit is 1 at the moment of sampling.
- R6: Diagnostic flags are captured when a matching read address is received, and the captured byte does not change while it is being shifted out. A later read returns the new flags.
- R7: With enable=0 the target code is 0 (off), whatever the other bits and the pin are.
- R8: With enable=1 and auxiliary=1 the target code is 6 (22 V class), whatever voltage select, line-loss compensation and the pin are.
- R9: With enable=1, auxiliary=0 and vctrl_i=0 the target code is 5 (13.4 V class), whatever voltage select and line-loss compensation are.
- R10: With enable=1, auxiliary=0 and vctrl_i=1 the target code follows {vsel,llc}: 00 gives 1 (13 V), 01 gives 2 (14 V), 10 gives 3 (18.5 V), 11 gives 4 (19.5 V).
- R11: A repeated START after a write, without STOP, starts a new address phase, so a read can follow a write in one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Selects ADDR_LO (0) or ADDR_HI (1) |
| vctrl_i | input | 1 | Voltage-control pin, low forces the 13.4 V code |
| diag_i | input | 5 | Live flags: min-current, out-voltage, tone, over-temp, overload |
| en_o | output | 1 | Supply enable |
| vsel_o | output | 1 | Voltage select (high level) |
| llc_o | output | 1 | Line-loss compensation (+1 step) |
| ten_o | output | 1 | Continuous tone enable |
| ttx_o | output | 1 | Tone transmit path enable |
| aux_o | output | 1 | Auxiliary highest-voltage request |
| itest_o | output | 1 | Minimum-current test level |
| pcl_o | output | 1 | Pulsed current limiting select |
| vtarget_o | output | 3 | Output-voltage target code |

## Verification
Each bus line reaches the state machine about three clocks after it changes: two synchronizer flops and one edge flop. The acknowledge and each read bit are therefore driven that long after the SCL falling edge. The bench holds every SCL phase for eight clocks and samples the data line in the middle of the SCL high phase, well after that latency.

Control outputs change one clock after the ACK edge of a data byte, so the bench checks them only after the STOP has completed. The voltage target code is combinational from the register and the pin, and the bench checks it one clock after the pin changes. The captured status byte is fixed from the address phase onward, which lets the bench change the flags between read bits and still expect the earlier values.

// File: rtl/supi2c_pkg.sv
package supi2c_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int DIAG_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR_DATA  = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD_DATA  = 3'd5,
        ST_RD_ACK   = 3'd6
    } tgt_state_e;

    typedef enum logic [2:0] {
        VT_OFF   = 3'd0,
        VT_13    = 3'd1,
        VT_14    = 3'd2,
        VT_18P5  = 3'd3,
        VT_19P5  = 3'd4,
        VT_13P4  = 3'd5,
        VT_22    = 3'd6
    } vtgt_e;

    typedef struct packed {
        logic aux;
        logic itest;
        logic pcl;
        logic ttx;
        logic ten;
        logic llc;
        logic vsel;
        logic en;
    } ctrl_t;

    localparam int DIAG_VMON_BIT = 3;

endpackage

// File: rtl/supi2c_sync.sv
module supi2c_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-1:0], raw[g]};
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/supi2c_vdecode.sv
module supi2c_vdecode
    import supi2c_pkg::*;
(
    input  logic  en,
    input  logic  aux,
    input  logic  vsel,
    input  logic  llc,
    input  logic  pin_hi,
    output vtgt_e vtgt
);

    always_comb begin
        if (!en) begin
            vtgt = VT_OFF;
        end else if (aux) begin
            vtgt = VT_22;
        end else if (!pin_hi) begin
            vtgt = VT_13P4;
        end else begin
            unique case ({vsel, llc})
                2'b00:   vtgt = VT_13;
                2'b01:   vtgt = VT_14;
                2'b10:   vtgt = VT_18P5;
                default: vtgt = VT_19P5;
            endcase
        end
    end

endmodule

// File: rtl/supi2c_target_fsm.sv
module supi2c_target_fsm
    import supi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] rd_word,
    output logic              snap_stb,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    tgt_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              mack;
    logic              start_c, stop_c, addr_hit, byte_end;

    assign start_c  = sda_fall & scl_lvl;
    assign stop_c   = sda_rise & scl_lvl;
    assign addr_hit = (sh[BYTE_W-1:1] == own_addr);
    assign byte_end = scl_fall && (cnt == CNT_FULL);

    // next-state selection
    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = ST_IDLE;
        end else if (start_c) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = sh[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_DATA:  if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack ? ST_RD_DATA : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            mack  <= 1'b0;
        end else begin
            state <= nxt;
            if (start_c || stop_c) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise && cnt != CNT_FULL) begin
                            sh  <= {sh[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (sh[0]) sh <= rd_word;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) cnt <= '0;
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt != CNT_FULL) begin
                            sh <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                        if (scl_fall) begin
                            cnt <= '0;
                            sh  <= rd_word;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        snap_stb = 1'b0;
        wr_stb   = 1'b0;
        sda_oe   = 1'b0;
        wr_data  = sh;
        unique case (state)
            ST_ADDR:     snap_stb = byte_end && addr_hit && sh[0];
            ST_ADDR_ACK: sda_oe = 1'b1;
            ST_WR_DATA:  wr_stb = byte_end;
            ST_WR_ACK:   sda_oe = 1'b1;
            ST_RD_DATA:  sda_oe = ~sh[BYTE_W-1];
            default:     ;
        endcase
    end

    // R2: a non-matching address never leads to an acknowledge phase
    p_nack_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_end && !addr_hit && !start_c && !stop_c) |=> (state == ST_IDLE));

    // R11: START seen in a data phase returns to address reception
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !stop_c && state == ST_WR_ACK) |=> (state == ST_ADDR && cnt == '0));

endmodule

// File: rtl/supi2c_ctl_regs.sv
module supi2c_ctl_regs
    import supi2c_pkg::*;
#(
    parameter logic [6:0] ADDR_LO     = 7'h08,
    parameter logic [6:0] ADDR_HI     = 7'h09,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       vctrl_i,
    input  logic [4:0] diag_i,
    output logic       en_o,
    output logic       vsel_o,
    output logic       llc_o,
    output logic       ten_o,
    output logic       ttx_o,
    output logic       aux_o,
    output logic       itest_o,
    output logic       pcl_o,
    output logic [2:0] vtarget_o
);

    logic [1:0]        ln_lvl, ln_rise, ln_fall;
    logic [ADDR_W-1:0] own_addr;
    logic              snap_stb, wr_stb;
    logic [BYTE_W-1:0] wr_data, live_word, shadow_q;
    ctrl_t             ctrl_q;
    vtgt_e             vtgt;

    supi2c_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .lvl  (ln_lvl),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    assign own_addr = addr_sel ? ADDR_HI : ADDR_LO;

    supi2c_target_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (ln_lvl[0]),
        .scl_rise(ln_rise[0]),
        .scl_fall(ln_fall[0]),
        .sda_lvl (ln_lvl[1]),
        .sda_rise(ln_rise[1]),
        .sda_fall(ln_fall[1]),
        .own_addr(own_addr),
        .rd_word (shadow_q),
        .snap_stb(snap_stb),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_stb) begin
            ctrl_q <= ctrl_t'(wr_data);
        end
    end

    assign live_word = {ctrl_q.llc, ctrl_q.vsel, ctrl_q.en,
                        diag_i[4],
                        diag_i[DIAG_VMON_BIT] & ~ctrl_q.llc,
                        diag_i[2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (snap_stb) begin
            shadow_q <= live_word;
        end
    end

    supi2c_vdecode u_vdec (
        .en    (ctrl_q.en),
        .aux   (ctrl_q.aux),
        .vsel  (ctrl_q.vsel),
        .llc   (ctrl_q.llc),
        .pin_hi(vctrl_i),
        .vtgt  (vtgt)
    );

    assign en_o      = ctrl_q.en;
    assign vsel_o    = ctrl_q.vsel;
    assign llc_o     = ctrl_q.llc;
    assign ten_o     = ctrl_q.ten;
    assign ttx_o     = ctrl_q.ttx;
    assign aux_o     = ctrl_q.aux;
    assign itest_o   = ctrl_q.itest;
    assign pcl_o     = ctrl_q.pcl;
    assign vtarget_o = vtgt;

    // R3: the control register moves only after a data-byte acknowledge strobe
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(ctrl_q));

    // R6: captured status holds except right after a read-address capture
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap_stb) |-> $stable(shadow_q));

    // R5: output-voltage flag captured as 0 while compensation is on
    p_vmon_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(snap_stb) && $past(ctrl_q.llc)) |-> !shadow_q[DIAG_VMON_BIT]);

    // R7: disabled supply always decodes to the off code
    p_off_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> (vtarget_o == 3'd0));

    // R8: auxiliary request wins over select bits and pin
    p_aux_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && aux_o) |-> (vtarget_o == 3'd6));

endmodule

// File: tb/supi2c_ctl_regs_tb.sv
module supi2c_ctl_regs_tb;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       vctrl = 1'b1;
    logic [4:0] diag = 5'b0;
    logic       sda_oe, sda_line;
    logic       en_o, vsel_o, llc_o, ten_o, ttx_o, aux_o, itest_o, pcl_o;
    logic [2:0] vtarget;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    supi2c_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .vctrl_i(vctrl), .diag_i(diag),
        .en_o(en_o), .vsel_o(vsel_o), .llc_o(llc_o), .ten_o(ten_o), .ttx_o(ttx_o),
        .aux_o(aux_o), .itest_o(itest_o), .pcl_o(pcl_o), .vtarget_o(vtarget)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] outs();
        return {aux_o, itest_o, pcl_o, ttx_o, ten_o, llc_o, vsel_o, en_o};
    endfunction

    function automatic int exp_vt(input logic [7:0] c, input logic pin);
        if (!c[0]) return 0;
        if (c[7]) return 6;
        if (!pin) return 5;
        case (c[2:1])
            2'b00:   return 1;
            2'b10:   return 2;
            2'b01:   return 3;
            default: return 4;
        endcase
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(Q); scl_m = 1'b1; wt(2 * Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack, input int flip_at,
                             input logic [4:0] flip_val);
        for (int i = 7; i >= 0; i--) begin
            if (i == flip_at) diag = flip_val;
            recv_bit(d[i]);
        end
        send_bit(~ack);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d, output logic aa);
        logic ad;
        i2c_start();
        send_byte({a, 1'b0}, aa);
        send_byte(d, ad);
        i2c_stop();
        wt(4);
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] d, output logic aa,
                          input int flip_at, input logic [4:0] flip_val);
        i2c_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(d, 1'b0, flip_at, flip_val);
        i2c_stop();
        wt(4);
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] c, input logic [4:0] f);
        return {c[2], c[1], c[0], f[4], f[3] & ~c[2], f[2:0]};
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       aa;
        logic [7:0] rd, cur, v;
        logic [4:0] f;

        wt(5);
        rst_n = 1'b1;
        wt(3);
        // R1 reset state
        chk("R1 ctrl", int'(outs()), 0);
        chk("R1 vtarget", int'(vtarget), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        cur = 8'h00;

        // R2 address sweep
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int a = 0; a < 32; a++) begin
                i2c_start();
                send_byte({a[6:0], 1'b0}, aa);
                if (a == 8 + s) begin
                    send_byte(cur, aa);
                    i2c_stop(); wt(4);
                    chk("R2 ack own", int'(outs()), int'(cur));
                end else begin
                    send_byte(8'hFF, aa);
                    i2c_stop(); wt(4);
                    chk("R2 foreign ignored", int'(outs()), int'(cur));
                end
                chk("R2 ack bit", int'(aa), int'(a == 8 + s));
            end
        end
        addr_sel = 1'b0;

        // R3/R4/R5 write and read sweep
        for (int i = 0; i < 16; i++) begin
            v = 8'(i * 8'h11) ^ 8'(i << 2);
            f = 5'(i * 7 + 3);
            diag = f;
            wr_reg(7'h08, v, aa);
            cur = v;
            chk("R3 write map", int'(outs()), int'(v));
            rd_reg(7'h08, rd, aa, -1, f);
            chk("R4 read layout", int'(rd), int'(exp_rd(cur, f)));
            if (cur[2] && f[3]) chk("R5 vmon masked", int'(rd[3]), 0);
        end
        // R4 all flags clear
        diag = 5'b0;
        rd_reg(7'h08, rd, aa, -1, 5'b0);
        chk("R4 flags clear", int'(rd[4:0]), 0);

        // R3 multi-byte write: last byte wins
        i2c_start();
        send_byte({7'h08, 1'b0}, aa);
        send_byte(8'h5A, aa);
        send_byte(8'hC3, aa);
        i2c_stop(); wt(4);
        cur = 8'hC3;
        chk("R3 second byte", int'(outs()), 8'hC3);

        // R6 shadow stability
        wr_reg(7'h08, 8'h01, aa);
        cur = 8'h01;
        diag = 5'b10101;
        rd_reg(7'h08, rd, aa, 4, 5'b01010);
        chk("R6 stable byte", int'(rd), int'(exp_rd(cur, 5'b10101)));
        rd_reg(7'h08, rd, aa, -1, 5'b01010);
        chk("R6 new flags", int'(rd), int'(exp_rd(cur, 5'b01010)));

        // R7..R10 decode sweep over en,vsel,llc,aux and pin
        for (int k = 0; k < 16; k++) begin
            v = {k[3], 4'b0101, k[2], k[1], k[0]};
            wr_reg(7'h08, v, aa);
            cur = v;
            for (int p = 0; p < 2; p++) begin
                vctrl = p[0];
                wt(1);
                if (!v[0]) chk("R7 off", int'(vtarget), exp_vt(v, vctrl));
                else if (v[7]) chk("R8 aux", int'(vtarget), exp_vt(v, vctrl));
                else if (!vctrl) chk("R9 pin low", int'(vtarget), exp_vt(v, vctrl));
                else chk("R10 select", int'(vtarget), exp_vt(v, vctrl));
            end
        end
        vctrl = 1'b1;

        // R11 write then repeated START read
        diag = 5'b00011;
        i2c_start();
        send_byte({7'h08, 1'b0}, aa);
        send_byte(8'h06, aa);
        i2c_start();
        send_byte({7'h08, 1'b1}, aa);
        chk("R11 read ack", int'(aa), 1);
        recv_byte(rd, 1'b0, -1, 5'b00011);
        i2c_stop(); wt(4);
        cur = 8'h06;
        chk("R11 outputs", int'(outs()), 8'h06);
        chk("R11 read", int'(rd), int'(exp_rd(cur, 5'b00011)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule